// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block prepares the setup values for a scaling engine that can resize a single display plane. One request carries the plane's source size in unsigned 16.16 fixed point, its destination size in whole pixels, a rotation flag and a bitmask with one bit per plane that asks for scaling. The block returns the following values:

- the effective input and output dimensions;
- per axis, the polyphase start value (initial phase) and step value (delta phase);
- per axis, the upscale ratio in 16.16;
- an enhancer enable, a scale enable and an error flag.

All quotients come from one shared sequential restoring divider. The divider produces one quotient bit per clock. A full calculation runs six divisions one after another.

A request is offered with `req_valid` and taken on a clock edge where `req_ready` is also high. `req_ready` is low from that edge until the result is published. Any request offered in that window is not taken, so the requester must keep it valid until `req_ready` returns. Results appear together with a one-cycle `done` pulse. They stay unchanged until the next request is taken. The result side has no back-pressure: the consumer captures the values at `done` or at any later time before it sends a new request.

Top module: `scl_phase_calc`

## Requirements
- R1: A taken request whose plane mask is all zeros produces `done` in the cycle after acceptance, with `scale_en`=0, `err`=0 and every numeric result zero; no division is run.
- R2: A taken request whose mask has two or more bits set (bit i = plane i) produces `done` in the cycle after acceptance, with `err`=1, `scale_en`=0 and every numeric result zero.
- R3: On a successful job, `h_up` = (dst_w·2^32)/src_w and `v_up` = (dst_h·2^32)/src_h. Both divisions use the un-rotated 16.16 source sizes, and each result is truncated to 32 bits.
- R4: On a successful job, `enh_en` is 1 exactly when bits [31:16] of `h_up` or of `v_up` are 2 or more.
- R5: `in_w`/`in_h` are the integer parts (bits [31:16]) of src_w/src_h. When `req_rotated`=1 they are swapped: `in_w` comes from src_h and `in_h` from src_w. `out_w`/`out_h` equal the destination sizes.
- R6: The initial phase per axis is ((in·16)/out + 1)/2, where each division is an integer quotient.
- R7: The delta phase per axis is (in·65536)/out, an integer quotient.
- R8: A single-plane request with a zero destination size or a zero source size produces `done` in the cycle after acceptance, with `err`=1, `scale_en`=0 and no division.
- R9: `req_ready` is low from acceptance until `done`. A request offered while `req_ready` is low has no effect on any result.
- R10: After `done`, every result output keeps its value until the next request is taken.
- R11: A single-plane request with nonzero sizes ends with one `done` pulse, `scale_en`=1 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_src_w | input | FIX_W | Source width, 16.16 |
| req_src_h | input | FIX_W | Source height, 16.16 |
| req_dst_w | input | DIM_W | Destination width, pixels |
| req_dst_h | input | DIM_W | Destination height, pixels |
| req_rotated | input | 1 | Plane turned by 90 or 270 degrees |
| req_plane_mask | input | NPLANES | One bit per plane asking for scaling |
| done | output | 1 | One-cycle result pulse |
| scale_en | output | 1 | Scaling engine in use |
| err | output | 1 | Request rejected |
| enh_en | output | 1 | Enhancer enable |
| in_w | output | FIX_W-FRAC_W | Effective input width |
| in_h | output | FIX_W-FRAC_W | Effective input height |
| out_w | output | DIM_W | Output width |
| out_h | output | DIM_W | Output height |
| h_init | output | FIX_W | Horizontal initial phase |
| h_delta | output | FIX_W | Horizontal delta phase |
| v_init | output | FIX_W | Vertical initial phase |
| v_delta | output | FIX_W | Vertical delta phase |
| h_up | output | FIX_W | Horizontal upscale ratio, 16.16 |
| v_up | output | FIX_W | Vertical upscale ratio, 16.16 |

## Verification
The assertions look at the request fields only on the edge where a request is taken. They assume those fields carry known values then, and they assume `rst_n` is held low for at least one edge before the first request. The bench sets every request field before reset is released. It changes the fields and `req_valid` only on falling clock edges, so each accepting edge sees settled, defined values. For the bound on the delta phase, the bench includes jobs where the input is smaller than the output and jobs where it is larger.

// File: rtl/scl_pkg.sv
`timescale 1ns/1ps
package scl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } scl_state_t;

  // Division order: both ratios first, so the enhancer decision is known early.
  typedef enum logic [2:0] {
    OP_HUP    = 3'd0,
    OP_VUP    = 3'd1,
    OP_HINIT  = 3'd2,
    OP_HDELTA = 3'd3,
    OP_VINIT  = 3'd4,
    OP_VDELTA = 3'd5
  } scl_op_t;
endpackage

// File: rtl/scl_div.sv
`timescale 1ns/1ps
// Restoring radix-2 divider: one quotient bit per clock, low quotient bits out.
module scl_div #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32,
  parameter int QUO_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [QUO_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             busy;
  logic [DEN_W-1:0] rem;
  logic [NUM_W-1:0] acc;
  logic [DEN_W-1:0] dsr;
  logic [CNT_W-1:0] cnt;

  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             take;

  assign trial = {rem, acc[NUM_W-1]};
  assign diff  = trial - {1'b0, dsr};
  assign take  = (trial >= {1'b0, dsr});
  assign quo   = acc[QUO_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      rem  <= '0;
      acc  <= '0;
      dsr  <= '0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          rem  <= '0;
          acc  <= num;
          dsr  <= den;
          cnt  <= CNT_W'(NUM_W);
        end
      end else begin
        rem <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        acc <= {acc[NUM_W-2:0], take};
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scl_mask_chk.sv
`timescale 1ns/1ps
// Classifies the plane mask: no plane, or more than one plane.
module scl_mask_chk #(
  parameter int NPLANES = 4
) (
  input  logic [NPLANES-1:0] mask,
  output logic               none,
  output logic               multi
);
  localparam int CW = $clog2(NPLANES + 1);

  logic [CW-1:0] tally [NPLANES+1];

  assign tally[0] = '0;
  for (genvar i = 0; i < NPLANES; i++) begin : g_tally
    assign tally[i+1] = tally[i] + CW'(mask[i]);
  end

  assign none  = (tally[NPLANES] == '0);
  assign multi = (tally[NPLANES] > CW'(1));
endmodule

// File: rtl/scl_geom.sv
`timescale 1ns/1ps
// Axis selection for rotated planes and zero-size detection.
module scl_geom #(
  parameter int FIX_W  = 32,
  parameter int FRAC_W = 16,
  parameter int DIM_W  = 16
) (
  input  logic [FIX_W-1:0]        src_w,
  input  logic [FIX_W-1:0]        src_h,
  input  logic [DIM_W-1:0]        dst_w,
  input  logic [DIM_W-1:0]        dst_h,
  input  logic                    rotated,
  output logic [FIX_W-FRAC_W-1:0] in_w,
  output logic [FIX_W-FRAC_W-1:0] in_h,
  output logic                    size_zero
);
  logic [FIX_W-FRAC_W-1:0] int_w;
  logic [FIX_W-FRAC_W-1:0] int_h;

  assign int_w = src_w[FIX_W-1:FRAC_W];
  assign int_h = src_h[FIX_W-1:FRAC_W];

  always_comb begin
    if (rotated) begin
      in_w = int_h;
      in_h = int_w;
    end else begin
      in_w = int_w;
      in_h = int_h;
    end
  end

  assign size_zero = (src_w == '0) || (src_h == '0) ||
                     (dst_w == '0) || (dst_h == '0);
endmodule

// File: rtl/scl_opsel.sv
`timescale 1ns/1ps
// Chooses dividend and divisor for the current step of the sequence.
module scl_opsel
  import scl_pkg::*;
#(
  parameter int FIX_W      = 32,
  parameter int FRAC_W     = 16,
  parameter int DIM_W      = 16,
  parameter int PHASE_BITS = 4,
  parameter int SHIFT_BITS = 12,
  parameter int NUM_W      = 48
) (
  input  scl_op_t                 op,
  input  logic [FIX_W-1:0]        src_w,
  input  logic [FIX_W-1:0]        src_h,
  input  logic [DIM_W-1:0]        dst_w,
  input  logic [DIM_W-1:0]        dst_h,
  input  logic [FIX_W-FRAC_W-1:0] in_w,
  input  logic [FIX_W-FRAC_W-1:0] in_h,
  output logic [NUM_W-1:0]        num,
  output logic [FIX_W-1:0]        den
);
  localparam int RATIO_SH = 2 * FRAC_W;
  localparam int STEP_SH  = PHASE_BITS + SHIFT_BITS;

  always_comb begin
    unique case (op)
      OP_HUP: begin
        num = NUM_W'(dst_w) << RATIO_SH;
        den = src_w;
      end
      OP_VUP: begin
        num = NUM_W'(dst_h) << RATIO_SH;
        den = src_h;
      end
      OP_HINIT: begin
        num = NUM_W'(in_w) << PHASE_BITS;
        den = FIX_W'(dst_w);
      end
      OP_HDELTA: begin
        num = NUM_W'(in_w) << STEP_SH;
        den = FIX_W'(dst_w);
      end
      OP_VINIT: begin
        num = NUM_W'(in_h) << PHASE_BITS;
        den = FIX_W'(dst_h);
      end
      OP_VDELTA: begin
        num = NUM_W'(in_h) << STEP_SH;
        den = FIX_W'(dst_h);
      end
      default: begin
        num = '0;
        den = FIX_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/scl_phase_calc.sv
`timescale 1ns/1ps
module scl_phase_calc
  import scl_pkg::*;
#(
  parameter int NPLANES    = 4,
  parameter int FIX_W      = 32,
  parameter int FRAC_W     = 16,
  parameter int DIM_W      = 16,
  parameter int PHASE_BITS = 4,
  parameter int SHIFT_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [FIX_W-1:0]        req_src_w,
  input  logic [FIX_W-1:0]        req_src_h,
  input  logic [DIM_W-1:0]        req_dst_w,
  input  logic [DIM_W-1:0]        req_dst_h,
  input  logic                    req_rotated,
  input  logic [NPLANES-1:0]      req_plane_mask,
  output logic                    done,
  output logic                    scale_en,
  output logic                    err,
  output logic                    enh_en,
  output logic [FIX_W-FRAC_W-1:0] in_w,
  output logic [FIX_W-FRAC_W-1:0] in_h,
  output logic [DIM_W-1:0]        out_w,
  output logic [DIM_W-1:0]        out_h,
  output logic [FIX_W-1:0]        h_init,
  output logic [FIX_W-1:0]        h_delta,
  output logic [FIX_W-1:0]        v_init,
  output logic [FIX_W-1:0]        v_delta,
  output logic [FIX_W-1:0]        h_up,
  output logic [FIX_W-1:0]        v_up
);
  localparam int INT_W = FIX_W - FRAC_W;
  localparam int NUM_W = DIM_W + 2 * FRAC_W;
  localparam logic [INT_W-1:0] ENH_MIN = INT_W'(2);

  scl_state_t       state;
  scl_op_t          op;
  logic [FIX_W-1:0] src_w_q;
  logic [FIX_W-1:0] src_h_q;

  logic             accept;
  logic             m_none;
  logic             m_multi;
  logic [INT_W-1:0] g_in_w;
  logic [INT_W-1:0] g_in_h;
  logic             g_zero;

  logic [NUM_W-1:0] d_num;
  logic [FIX_W-1:0] d_den;
  logic             d_start;
  logic             d_done;
  logic [FIX_W-1:0] d_quo;
  logic [FIX_W-1:0] init_val;
  logic             enh_next;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign d_start   = (state == ST_LAUNCH);

  // (q + 1) / 2 written without a carry bit that would be dropped
  assign init_val  = {1'b0, d_quo[FIX_W-1:1]} + {{(FIX_W-1){1'b0}}, d_quo[0]};
  assign enh_next  = (h_up[FIX_W-1:FRAC_W] >= ENH_MIN) ||
                     (d_quo[FIX_W-1:FRAC_W] >= ENH_MIN);

  scl_mask_chk #(.NPLANES(NPLANES)) u_mask (
    .mask  (req_plane_mask),
    .none  (m_none),
    .multi (m_multi)
  );

  scl_geom #(.FIX_W(FIX_W), .FRAC_W(FRAC_W), .DIM_W(DIM_W)) u_geom (
    .src_w     (req_src_w),
    .src_h     (req_src_h),
    .dst_w     (req_dst_w),
    .dst_h     (req_dst_h),
    .rotated   (req_rotated),
    .in_w      (g_in_w),
    .in_h      (g_in_h),
    .size_zero (g_zero)
  );

  scl_opsel #(
    .FIX_W(FIX_W), .FRAC_W(FRAC_W), .DIM_W(DIM_W),
    .PHASE_BITS(PHASE_BITS), .SHIFT_BITS(SHIFT_BITS), .NUM_W(NUM_W)
  ) u_opsel (
    .op    (op),
    .src_w (src_w_q),
    .src_h (src_h_q),
    .dst_w (out_w),
    .dst_h (out_h),
    .in_w  (in_w),
    .in_h  (in_h),
    .num   (d_num),
    .den   (d_den)
  );

  scl_div #(.NUM_W(NUM_W), .DEN_W(FIX_W), .QUO_W(FIX_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (d_start),
    .num   (d_num),
    .den   (d_den),
    .done  (d_done),
    .quo   (d_quo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op       <= OP_HUP;
      src_w_q  <= '0;
      src_h_q  <= '0;
      done     <= 1'b0;
      scale_en <= 1'b0;
      err      <= 1'b0;
      enh_en   <= 1'b0;
      in_w     <= '0;
      in_h     <= '0;
      out_w    <= '0;
      out_h    <= '0;
      h_init   <= '0;
      h_delta  <= '0;
      v_init   <= '0;
      v_delta  <= '0;
      h_up     <= '0;
      v_up     <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            scale_en <= 1'b0;
            err      <= 1'b0;
            enh_en   <= 1'b0;
            in_w     <= '0;
            in_h     <= '0;
            out_w    <= '0;
            out_h    <= '0;
            h_init   <= '0;
            h_delta  <= '0;
            v_init   <= '0;
            v_delta  <= '0;
            h_up     <= '0;
            v_up     <= '0;
            if (m_none) begin
              done <= 1'b1;
            end else if (m_multi || g_zero) begin
              err  <= 1'b1;
              done <= 1'b1;
            end else begin
              src_w_q <= req_src_w;
              src_h_q <= req_src_h;
              in_w    <= g_in_w;
              in_h    <= g_in_h;
              out_w   <= req_dst_w;
              out_h   <= req_dst_h;
              op      <= OP_HUP;
              state   <= ST_LAUNCH;
            end
          end
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: begin
          if (d_done) begin
            unique case (op)
              OP_HUP:    h_up    <= d_quo;
              OP_VUP: begin
                v_up   <= d_quo;
                enh_en <= enh_next;
              end
              OP_HINIT:  h_init  <= init_val;
              OP_HDELTA: h_delta <= d_quo;
              OP_VINIT:  v_init  <= init_val;
              default:   v_delta <= d_quo;
            endcase
            if (op == OP_VDELTA) begin
              scale_en <= 1'b1;
              done     <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              op    <= scl_op_t'(op + 3'd1);
              state <= ST_LAUNCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scl_calc_chk.sv
`timescale 1ns/1ps
module scl_calc_chk #(
  parameter int NPLANES    = 4,
  parameter int FIX_W      = 32,
  parameter int FRAC_W     = 16,
  parameter int DIM_W      = 16,
  parameter int PHASE_BITS = 4,
  parameter int SHIFT_BITS = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [FIX_W-1:0]        req_src_w,
  input logic [FIX_W-1:0]        req_src_h,
  input logic [DIM_W-1:0]        req_dst_w,
  input logic [DIM_W-1:0]        req_dst_h,
  input logic [NPLANES-1:0]      req_plane_mask,
  input logic                    done,
  input logic                    scale_en,
  input logic                    err,
  input logic [FIX_W-FRAC_W-1:0] in_w,
  input logic [DIM_W-1:0]        out_w,
  input logic [FIX_W-1:0]        h_delta,
  input logic [FIX_W-1:0]        v_delta
);
  localparam logic [FIX_W-1:0] UNIT_STEP = FIX_W'(1) << (PHASE_BITS + SHIFT_BITS);

  logic take;
  logic any_zero;
  assign take     = req_valid && req_ready;
  assign any_zero = (req_src_w == '0) || (req_src_h == '0) ||
                    (req_dst_w == '0) || (req_dst_h == '0);

  p_nomask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_plane_mask == '0) |=> (done && !scale_en && !err));

  p_multi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $countones(req_plane_mask) > 1) |=> (done && err && !scale_en));

  p_zero_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $countones(req_plane_mask) == 1 && any_zero) |=> (done && err && !scale_en));

  p_step_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && scale_en && FIX_W'(in_w) <= FIX_W'(out_w)) |-> (h_delta <= UNIT_STEP));

  p_ready_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(h_delta) && $stable(v_delta) &&
                                   $stable(scale_en) && $stable(err)));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(scale_en && err));
endmodule

bind scl_phase_calc scl_calc_chk #(
  .NPLANES(NPLANES), .FIX_W(FIX_W), .FRAC_W(FRAC_W), .DIM_W(DIM_W),
  .PHASE_BITS(PHASE_BITS), .SHIFT_BITS(SHIFT_BITS)
) u_scl_calc_chk (.*);

// File: tb/test_scl_phase_calc.sv
`timescale 1ns/1ps
module test_scl_phase_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_src_w = '0;
  logic [31:0] req_src_h = '0;
  logic [15:0] req_dst_w = '0;
  logic [15:0] req_dst_h = '0;
  logic        req_rotated = 1'b0;
  logic [3:0]  req_plane_mask = '0;
  logic        done, scale_en, err, enh_en;
  logic [15:0] in_w, in_h, out_w, out_h;
  logic [31:0] h_init, h_delta, v_init, v_delta, h_up, v_up;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  scl_phase_calc i_scl_phase_calc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src_w(req_src_w), .req_src_h(req_src_h),
    .req_dst_w(req_dst_w), .req_dst_h(req_dst_h),
    .req_rotated(req_rotated), .req_plane_mask(req_plane_mask),
    .done(done), .scale_en(scale_en), .err(err), .enh_en(enh_en),
    .in_w(in_w), .in_h(in_h), .out_w(out_w), .out_h(out_h),
    .h_init(h_init), .h_delta(h_delta), .v_init(v_init), .v_delta(v_delta),
    .h_up(h_up), .v_up(v_up)
  );

  task automatic chk(input string what, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Offers one request, returns the number of edges from acceptance to done.
  task automatic run_job(input logic [31:0] sw, input logic [31:0] sh,
                         input logic [15:0] dw, input logic [15:0] dh,
                         input logic rot, input logic [3:0] mask, output int lat);
    @(negedge clk);
    req_src_w = sw; req_src_h = sh; req_dst_w = dw; req_dst_h = dh;
    req_rotated = rot; req_plane_mask = mask; req_valid = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    #1;
    // done is registered on the accepting edge and seen right after it
    while (!done && lat < 2000) begin
      @(posedge clk);
      #1;
      lat++;
    end
  endtask

  task automatic expect_scaled(input string tag, input logic [31:0] sw, input logic [31:0] sh,
                               input logic [15:0] dw, input logic [15:0] dh, input logic rot);
    longint unsigned iw, ih, hu, vu, hi, hd, vi, vd;
    logic en;
    iw = rot ? longint'(sh >> 16) : longint'(sw >> 16);
    ih = rot ? longint'(sw >> 16) : longint'(sh >> 16);
    hu = ((longint'(dw) << 32) / sw) & 64'hFFFF_FFFF;
    vu = ((longint'(dh) << 32) / sh) & 64'hFFFF_FFFF;
    hi = (((iw << 4) / dw) + 1) / 2;
    vi = (((ih << 4) / dh) + 1) / 2;
    hd = (iw << 16) / dw;
    vd = (ih << 16) / dh;
    en = ((hu >> 16) >= 2) || ((vu >> 16) >= 2);
    chk({tag, " R11 done"}, done, 1);
    chk({tag, " R11 scale_en"}, scale_en, 1);
    chk({tag, " R11 err"}, err, 0);
    chk({tag, " R5 in_w"}, in_w, iw);
    chk({tag, " R5 in_h"}, in_h, ih);
    chk({tag, " R5 out_w"}, out_w, dw);
    chk({tag, " R5 out_h"}, out_h, dh);
    chk({tag, " R3 h_up"}, h_up, hu);
    chk({tag, " R3 v_up"}, v_up, vu);
    chk({tag, " R4 enh_en"}, enh_en, en);
    chk({tag, " R6 h_init"}, h_init, hi);
    chk({tag, " R6 v_init"}, v_init, vi);
    chk({tag, " R7 h_delta"}, h_delta, hd);
    chk({tag, " R7 v_delta"}, v_delta, vd);
  endtask

  task automatic expect_cleared(input string tag, input logic exp_err);
    chk({tag, " done"}, done, 1);
    chk({tag, " scale_en"}, scale_en, 0);
    chk({tag, " err"}, err, exp_err);
    chk({tag, " results zero"}, h_up | v_up | h_init | h_delta | v_init | v_delta |
                                {in_w, in_h} | {out_w, out_h}, 0);
  endtask

  task automatic t_reset;
    chk("reset req_ready", req_ready, 1);
    chk("reset done", done, 0);
    chk("reset scale_en", scale_en, 0);
    chk("reset err", err, 0);
  endtask

  task automatic t_no_plane_r1;
    int lat;
    run_job(32'h0064_0000, 32'h0064_0000, 16'd50, 16'd50, 1'b0, 4'b0000, lat);
    chk("R1 latency", lat, 0);
    expect_cleared("R1", 1'b0);
  endtask

  task automatic t_multi_plane_r2;
    int lat;
    run_job(32'h0064_0000, 32'h0064_0000, 16'd50, 16'd50, 1'b0, 4'b0101, lat);
    chk("R2 latency", lat, 0);
    expect_cleared("R2", 1'b1);
    run_job(32'h0064_0000, 32'h0064_0000, 16'd50, 16'd50, 1'b0, 4'b1111, lat);
    expect_cleared("R2 all", 1'b1);
  endtask

  task automatic t_zero_size_r8;
    int lat;
    run_job(32'h0064_0000, 32'h0064_0000, 16'd0, 16'd50, 1'b0, 4'b0010, lat);
    chk("R8 dst latency", lat, 0);
    expect_cleared("R8 dst", 1'b1);
    run_job(32'h0064_0000, 32'h0000_0000, 16'd40, 16'd50, 1'b0, 4'b0010, lat);
    chk("R8 src latency", lat, 0);
    expect_cleared("R8 src", 1'b1);
  endtask

  task automatic t_downscale;
    int lat;
    run_job(32'h0780_0000, 32'h0438_0000, 16'd960, 16'd540, 1'b0, 4'b0001, lat);
    expect_scaled("down", 32'h0780_0000, 32'h0438_0000, 16'd960, 16'd540, 1'b0);
    chk("down R4 enh off", enh_en, 0);
  endtask

  task automatic t_upscale;
    int lat;
    run_job(32'h0280_0000, 32'h01E0_0000, 16'd1920, 16'd1440, 1'b0, 4'b1000, lat);
    expect_scaled("up3", 32'h0280_0000, 32'h01E0_0000, 16'd1920, 16'd1440, 1'b0);
    chk("up3 R4 enh on", enh_en, 1);
  endtask

  task automatic t_enh_boundary_r4;
    int lat;
    // vertical ratio exactly 2.0: enhancer on
    run_job(32'h0064_0000, 32'h0064_0000, 16'd100, 16'd200, 1'b0, 4'b0100, lat);
    expect_scaled("v2", 32'h0064_0000, 32'h0064_0000, 16'd100, 16'd200, 1'b0);
    chk("v2 R4 enh at 2.0", enh_en, 1);
    // ratio just under 2.0: enhancer off
    run_job(32'h0064_0000, 32'h0064_0000, 16'd199, 16'd100, 1'b0, 4'b0100, lat);
    expect_scaled("h199", 32'h0064_0000, 32'h0064_0000, 16'd199, 16'd100, 1'b0);
    chk("h199 R4 enh below 2.0", enh_en, 0);
  endtask

  task automatic t_rotated_r5;
    int lat;
    run_job(32'h0438_0000, 32'h0780_0000, 16'd1920, 16'd1080, 1'b1, 4'b0010, lat);
    expect_scaled("rot", 32'h0438_0000, 32'h0780_0000, 16'd1920, 16'd1080, 1'b1);
    chk("rot R5 in_w from src_h", in_w, 1920);
    // fractional source with rotation
    run_job(32'h0064_8000, 32'h0032_0000, 16'd300, 16'd100, 1'b1, 4'b0010, lat);
    expect_scaled("frac", 32'h0064_8000, 32'h0032_0000, 16'd300, 16'd100, 1'b1);
  endtask

  task automatic t_busy_ignored_r9;
    int lat;
    @(negedge clk);
    req_src_w = 32'h0200_0000; req_src_h = 32'h0100_0000;
    req_dst_w = 16'd300; req_dst_h = 16'd700;
    req_rotated = 1'b0; req_plane_mask = 4'b0001; req_valid = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    chk("R9 ready low while busy", req_ready, 0);
    // a different request offered while busy
    req_src_w = 32'h0010_0000; req_src_h = 32'h0010_0000;
    req_dst_w = 16'd7; req_dst_h = 16'd9; req_rotated = 1'b1; req_plane_mask = 4'b0011;
    for (int k = 0; k < 12; k++) @(negedge clk);
    chk("R9 ready still low", req_ready, 0);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin
      @(posedge clk);
      #1;
      lat++;
    end
    expect_scaled("busy", 32'h0200_0000, 32'h0100_0000, 16'd300, 16'd700, 1'b0);
  endtask

  task automatic t_hold_r10;
    logic [31:0] hd, vd, hi, hu;
    hd = h_delta; vd = v_delta; hi = h_init; hu = h_up;
    for (int k = 0; k < 6; k++) @(posedge clk);
    #1;
    chk("R10 done single pulse", done, 0);
    chk("R10 h_delta held", h_delta, hd);
    chk("R10 v_delta held", v_delta, vd);
    chk("R10 h_init held", h_init, hi);
    chk("R10 h_up held", h_up, hu);
    chk("R10 scale_en held", scale_en, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_no_plane_r1();
    t_multi_plane_r2();
    t_zero_size_r8();
    t_downscale();
    t_upscale();
    t_enh_boundary_r4();
    t_rotated_r5();
    t_busy_ignored_r9();
    t_hold_r10();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule